// File: doc/BRIEF.md
# Sixteen-bit timer/counter with two compare channels and input capture

This block is a 16-bit up-counter that sits behind an 8-bit register bus. Every 16-bit quantity (the counter, two compare values and the capture value) is reached as a pair of byte addresses. One 8-bit holding byte is shared by all of them. It lets software move a full 16-bit value in two bus accesses without tearing. The counter advances once per cycle in which the timer enable `tick_i` is high.

Each compare channel watches the counter and raises a flag on equality. It also toggles its own waveform pin. The capture channel snapshots the counter on a chosen edge of either the capture pin or an alternative comparator input. In top mode the captured value becomes the wrap point of the counter. The event flags are combined with a mask register to form the interrupt requests. Software clears a flag by writing a 1 to it.

Top module: `tmr16_cc`

## Requirements
- R1: After reset every readable address returns 0x00, and `wave_o`, `irq_cmp_o`, `irq_cap_o` and `irq_ovf_o` are all low.
- R2: A write to a high-byte address (1 counter, 3 compare A, 5 compare B) loads the shared holding byte. A write to the matching low-byte address (0, 2, 4) commits {holding byte, written byte} to the 16-bit register in that cycle. Both compare bytes read back directly.
- R3: A write to the counter suppresses compare matches on both channels on the next tick; the tick after that compares normally.
- R4: Reading the counter low byte (address 0) or the capture low byte (address 6) copies the register's high byte into the holding byte. A following read of address 1 or 7 returns the holding byte, even if the register has changed since.
- R5: The holding byte is a single register shared by all pairs: a capture low-byte read between a compare high-byte write and its low-byte write changes the committed high byte.
- R6: With control bit 2 at address 10 set, a rising edge is selected, and with it clear a falling edge. The edge is taken after a two-flop synchronizer. It loads the capture register with the counter on the third clock edge after the input changes, and it sets flag bit 5.
- R7: With control bit 1 set, the alternative comparator input is the capture source and edges on the capture pin have no effect.
- R8: The capture register is read-only: writes to addresses 6 and 7 change neither the capture value nor the holding byte.
- R9: On a tick where the counter equals a compare value, that channel's flag is set (bit 1 for A, bit 2 for B at address 9) and its `wave_o` bit toggles.
- R10: With control bit 0 clear, the counter counts up once per tick and wraps from 0xFFFF to 0x0000, setting overflow flag bit 0.
- R11: With control bit 0 set, the counter wraps to 0 on the tick after it equals the capture value, and the overflow flag is not set.
- R12: The mask register at address 8 keeps bits 5, 2, 1 and 0 and reads the other bits as zero. Each interrupt output is its flag AND its mask bit.
- R13: Writing a 1 to a bit of the flag register at address 9 clears that flag; writing 0 leaves it unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_addr | input | 4 | Register address |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe (read side effects on the clock edge) |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for `bus_addr` |
| tick_i | input | 1 | Timer clock enable |
| cap_pin_i | input | 1 | Capture pin |
| cap_alt_i | input | 1 | Alternative (comparator) capture source |
| wave_o | output | 2 | Compare waveform outputs, bit 0 channel A |
| irq_cmp_o | output | 2 | Compare interrupt requests, bit 0 channel A |
| irq_cap_o | output | 1 | Capture interrupt request |
| irq_ovf_o | output | 1 | Overflow interrupt request |

## Verification
The holding-byte assertion assumes a read and a write never arrive in the same cycle, because the write would take the byte. The bench issues one bus access at a time with an idle cycle in between. The capture assertions assume the capture inputs are held for several clocks. The stimulus keeps every capture level for four cycles and leaves `tick_i` low during captures, so the captured counter value is known exactly.

// File: rtl/tmr16_pkg.sv
package tmr16_pkg;
  localparam int N_CMP = 2;
  // bus register addresses
  localparam logic [3:0] A_CNT_LO  = 4'h0;
  localparam logic [3:0] A_CNT_HI  = 4'h1;
  localparam logic [3:0] A_CMPA_LO = 4'h2;
  localparam logic [3:0] A_CMPA_HI = 4'h3;
  localparam logic [3:0] A_CMPB_LO = 4'h4;
  localparam logic [3:0] A_CMPB_HI = 4'h5;
  localparam logic [3:0] A_CAP_LO  = 4'h6;
  localparam logic [3:0] A_CAP_HI  = 4'h7;
  localparam logic [3:0] A_MASK    = 4'h8;
  localparam logic [3:0] A_FLAG    = 4'h9;
  localparam logic [3:0] A_CTRL    = 4'hA;
  // flag / mask bit positions
  localparam int FB_OVF  = 0;
  localparam int FB_CMPA = 1;
  localparam int FB_CAP  = 5;
  localparam logic [7:0] IRQ_BITS = 8'h27;
  // control bits
  localparam int CB_TOPCAP = 0;
  localparam int CB_ALTSRC = 1;
  localparam int CB_RISE   = 2;
  localparam int CTRL_W    = 3;
endpackage

// File: rtl/tmr16_cap_front.sv
module tmr16_cap_front #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_i,
  input  logic alt_i,
  input  logic use_alt_i,
  input  logic rise_i,
  output logic evt_o
);
  logic [STAGES-1:0] sync_q;
  logic              prev_q;
  logic              lvl;

  assign lvl = sync_q[STAGES-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
      prev_q <= 1'b0;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], (use_alt_i ? alt_i : pin_i)};
      prev_q <= lvl;
    end
  end

  assign evt_o = rise_i ? (lvl & ~prev_q) : (~lvl & prev_q);

  AST_EVT_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    evt_o && $stable(rise_i) |=> !evt_o); // R6
endmodule

// File: rtl/tmr16_counter.sv
module tmr16_counter #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tick_i,
  input  logic         wr_i,
  input  logic [W-1:0] wdata_i,
  input  logic         top_mode_i,
  input  logic [W-1:0] top_i,
  output logic [W-1:0] cnt_o,
  output logic         block_o,
  output logic         ovf_evt_o
);
  function automatic logic at_wrap(input logic [W-1:0] c, input logic tm,
                                   input logic [W-1:0] t);
    return tm ? (c == t) : (&c);
  endfunction

  logic [W-1:0] cnt_q;
  logic         block_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      block_q <= 1'b0;
    end else if (wr_i) begin
      cnt_q   <= wdata_i;
      block_q <= 1'b1;
    end else if (tick_i) begin
      cnt_q   <= at_wrap(cnt_q, top_mode_i, top_i) ? '0 : cnt_q + 1'b1;
      block_q <= 1'b0;
    end
  end

  assign cnt_o     = cnt_q;
  assign block_o   = block_q;
  assign ovf_evt_o = tick_i && !wr_i && !top_mode_i && (&cnt_q);

  AST_OVF_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_evt_o |=> cnt_q == '0); // R10
  AST_TOP_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    tick_i && !wr_i && top_mode_i && cnt_q == top_i |=> cnt_q == '0); // R11
  AST_BLOCK_AFTER_WR: assert property (@(posedge clk) disable iff (!rst_n)
    wr_i |=> block_q); // R3
endmodule

// File: rtl/tmr16_cmp_chan.sv
module tmr16_cmp_chan #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tick_i,
  input  logic         block_i,
  input  logic [W-1:0] cnt_i,
  input  logic         wr_i,
  input  logic [W-1:0] wval_i,
  output logic [W-1:0] cmp_o,
  output logic         hit_o,
  output logic         wave_o
);
  function automatic logic equal_now(input logic [W-1:0] c, input logic [W-1:0] r);
    return c == r;
  endfunction

  logic [W-1:0] cmp_q;
  logic         wave_q;

  assign hit_o = tick_i && !block_i && equal_now(cnt_i, cmp_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmp_q  <= '0;
      wave_q <= 1'b0;
    end else begin
      if (wr_i)  cmp_q  <= wval_i;
      if (hit_o) wave_q <= ~wave_q;
    end
  end

  assign cmp_o  = cmp_q;
  assign wave_o = wave_q;

  AST_WAVE_TOGGLE: assert property (@(posedge clk) disable iff (!rst_n)
    hit_o |=> wave_o != $past(wave_o)); // R9
  AST_WAVE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !hit_o |=> $stable(wave_o)); // R9
endmodule

// File: rtl/tmr16_cc.sv
module tmr16_cc
  import tmr16_pkg::*;
#(
  parameter int BUS_W       = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [3:0]       bus_addr,
  input  logic             bus_wr,
  input  logic             bus_rd,
  input  logic [BUS_W-1:0] bus_wdata,
  output logic [BUS_W-1:0] bus_rdata,
  input  logic             tick_i,
  input  logic             cap_pin_i,
  input  logic             cap_alt_i,
  output logic [N_CMP-1:0] wave_o,
  output logic [N_CMP-1:0] irq_cmp_o,
  output logic             irq_cap_o,
  output logic             irq_ovf_o
);
  localparam int CNT_W = 2 * BUS_W;

  logic [BUS_W-1:0]  temp_q;
  logic [CNT_W-1:0]  cap_q;
  logic [BUS_W-1:0]  mask_q;
  logic [BUS_W-1:0]  flags_q;
  logic [CTRL_W-1:0] ctrl_q;

  logic [CNT_W-1:0]  cnt;
  logic              blocked;
  logic              ovf_evt;
  logic              cap_evt;
  logic              cnt_wr;
  logic [CNT_W-1:0]  wide_wval;
  logic [N_CMP-1:0]  cmp_wr;
  logic [N_CMP-1:0]  cmp_hit;
  logic [CNT_W-1:0]  cmp_val [N_CMP];
  logic [BUS_W-1:0]  flag_set;
  logic [BUS_W-1:0]  flag_clr;
  logic              hi_wr;

  assign wide_wval = {temp_q, bus_wdata};
  assign cnt_wr    = bus_wr && (bus_addr == A_CNT_LO);
  assign hi_wr     = bus_wr && ((bus_addr == A_CNT_HI) || (bus_addr == A_CMPA_HI) ||
                                (bus_addr == A_CMPB_HI));

  tmr16_counter #(.W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .wr_i(cnt_wr), .wdata_i(wide_wval),
    .top_mode_i(ctrl_q[CB_TOPCAP]), .top_i(cap_q), .cnt_o(cnt), .block_o(blocked),
    .ovf_evt_o(ovf_evt)
  );

  for (genvar i = 0; i < N_CMP; i++) begin : g_cmp
    assign cmp_wr[i] = bus_wr && (bus_addr == 4'(A_CMPA_LO + 2 * i));
    tmr16_cmp_chan #(.W(CNT_W)) u_chan (
      .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .block_i(blocked), .cnt_i(cnt),
      .wr_i(cmp_wr[i]), .wval_i(wide_wval), .cmp_o(cmp_val[i]), .hit_o(cmp_hit[i]),
      .wave_o(wave_o[i])
    );
  end

  tmr16_cap_front #(.STAGES(SYNC_STAGES)) u_capf (
    .clk(clk), .rst_n(rst_n), .pin_i(cap_pin_i), .alt_i(cap_alt_i),
    .use_alt_i(ctrl_q[CB_ALTSRC]), .rise_i(ctrl_q[CB_RISE]), .evt_o(cap_evt)
  );

  always_comb begin
    flag_set         = '0;
    flag_set[FB_OVF] = ovf_evt;
    flag_set[FB_CAP] = cap_evt;
    for (int i = 0; i < N_CMP; i++) flag_set[FB_CMPA + i] = cmp_hit[i];
  end
  assign flag_clr = (bus_wr && bus_addr == A_FLAG) ? bus_wdata : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      temp_q  <= '0;
      cap_q   <= '0;
      mask_q  <= '0;
      flags_q <= '0;
      ctrl_q  <= '0;
    end else begin
      if (hi_wr)                                  temp_q <= bus_wdata;
      else if (bus_rd && bus_addr == A_CNT_LO)    temp_q <= cnt[CNT_W-1:BUS_W];
      else if (bus_rd && bus_addr == A_CAP_LO)    temp_q <= cap_q[CNT_W-1:BUS_W];
      if (cap_evt)                                cap_q  <= cnt;
      if (bus_wr && bus_addr == A_MASK)           mask_q <= bus_wdata & IRQ_BITS;
      if (bus_wr && bus_addr == A_CTRL)           ctrl_q <= bus_wdata[CTRL_W-1:0];
      flags_q <= ((flags_q & ~flag_clr) | flag_set) & IRQ_BITS;
    end
  end

  always_comb begin
    case (bus_addr)
      A_CNT_LO:  bus_rdata = cnt[BUS_W-1:0];
      A_CNT_HI:  bus_rdata = temp_q;
      A_CMPA_LO: bus_rdata = cmp_val[0][BUS_W-1:0];
      A_CMPA_HI: bus_rdata = cmp_val[0][CNT_W-1:BUS_W];
      A_CMPB_LO: bus_rdata = cmp_val[1][BUS_W-1:0];
      A_CMPB_HI: bus_rdata = cmp_val[1][CNT_W-1:BUS_W];
      A_CAP_LO:  bus_rdata = cap_q[BUS_W-1:0];
      A_CAP_HI:  bus_rdata = temp_q;
      A_MASK:    bus_rdata = mask_q;
      A_FLAG:    bus_rdata = flags_q;
      A_CTRL:    bus_rdata = {{(BUS_W-CTRL_W){1'b0}}, ctrl_q};
      default:   bus_rdata = '0;
    endcase
  end

  for (genvar i = 0; i < N_CMP; i++) begin : g_irq
    assign irq_cmp_o[i] = flags_q[FB_CMPA + i] & mask_q[FB_CMPA + i];
  end
  assign irq_cap_o = flags_q[FB_CAP] & mask_q[FB_CAP];
  assign irq_ovf_o = flags_q[FB_OVF] & mask_q[FB_OVF];

  AST_CAP_LOADS_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
    cap_evt |=> cap_q == $past(cnt)); // R6
  AST_TEMP_FROM_CAP: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rd && !bus_wr && bus_addr == A_CAP_LO |=> temp_q == $past(cap_q[CNT_W-1:BUS_W])); // R4
  AST_BLOCK_NO_HIT: assert property (@(posedge clk) disable iff (!rst_n)
    blocked && tick_i |-> cmp_hit == '0); // R3
  AST_CAP_RDONLY: assert property (@(posedge clk) disable iff (!rst_n)
    !cap_evt |=> $stable(cap_q)); // R8
  AST_FLAG_SET: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_evt |=> flags_q[FB_OVF]); // R10
endmodule

// File: tb/tmr16_cc_tb.sv
module tmr16_cc_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [3:0] bus_addr = '0;
  logic       bus_wr = 1'b0;
  logic       bus_rd = 1'b0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata;
  logic       tick_i = 1'b0;
  logic       cap_pin_i = 1'b0;
  logic       cap_alt_i = 1'b0;
  logic [1:0] wave_o;
  logic [1:0] irq_cmp_o;
  logic       irq_cap_o;
  logic       irq_ovf_o;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  tmr16_cc dut_i (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .tick_i(tick_i), .cap_pin_i(cap_pin_i),
    .cap_alt_i(cap_alt_i), .wave_o(wave_o), .irq_cmp_o(irq_cmp_o), .irq_cap_o(irq_cap_o),
    .irq_ovf_o(irq_ovf_o)
  );

  // {req[3:0], wr, addr[3:0], data[7:0]}; data is the expected value for reads
  localparam int NV = 28;
  localparam logic [16:0] VEC [NV] = '{
    {4'd1, 1'b0, 4'h0, 8'h00}, {4'd1, 1'b0, 4'h1, 8'h00}, {4'd1, 1'b0, 4'h2, 8'h00},
    {4'd1, 1'b0, 4'h3, 8'h00}, {4'd1, 1'b0, 4'h6, 8'h00}, {4'd1, 1'b0, 4'h7, 8'h00},
    {4'd1, 1'b0, 4'h8, 8'h00}, {4'd1, 1'b0, 4'h9, 8'h00}, {4'd1, 1'b0, 4'hA, 8'h00},
    {4'd2, 1'b1, 4'h3, 8'h12}, {4'd2, 1'b1, 4'h2, 8'h34}, {4'd2, 1'b0, 4'h2, 8'h34},
    {4'd2, 1'b0, 4'h3, 8'h12}, {4'd2, 1'b1, 4'h5, 8'h56}, {4'd2, 1'b1, 4'h4, 8'h78},
    {4'd2, 1'b0, 4'h5, 8'h56}, {4'd2, 1'b0, 4'h4, 8'h78}, {4'd8, 1'b1, 4'h7, 8'h99},
    {4'd8, 1'b1, 4'h6, 8'h77}, {4'd8, 1'b0, 4'h6, 8'h00}, {4'd8, 1'b0, 4'h7, 8'h00},
    {4'd12, 1'b1, 4'h8, 8'hFF}, {4'd12, 1'b0, 4'h8, 8'h27}, {4'd12, 1'b1, 4'h8, 8'h00},
    {4'd2, 1'b1, 4'h1, 8'hAB}, {4'd2, 1'b1, 4'h0, 8'hCD}, {4'd4, 1'b0, 4'h0, 8'hCD},
    {4'd4, 1'b0, 4'h1, 8'hAB}
  };

  function automatic string rtag(input logic [3:0] n);
    case (n)
      4'd1:    return "R1";
      4'd2:    return "R2";
      4'd4:    return "R4";
      4'd8:    return "R8";
      default: return "R12";
    endcase
  endfunction

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input string req, input logic [3:0] a, input logic [7:0] exp);
    @(negedge clk);
    bus_rd = 1'b1; bus_addr = a;
    #1 check(req, bus_rdata, exp);
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic wr16(input logic [3:0] lo, input logic [15:0] v);
    wr(lo + 4'd1, v[15:8]);
    wr(lo, v[7:0]);
  endtask

  task automatic ticks(input int n);
    @(negedge clk);
    tick_i = 1'b1;
    repeat (n) @(negedge clk);
    tick_i = 1'b0;
  endtask

  task automatic set_pin(input logic v);
    @(negedge clk); cap_pin_i = v;
    repeat (4) @(negedge clk);
  endtask

  task automatic set_alt(input logic v);
    @(negedge clk); cap_alt_i = v;
    repeat (4) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1", {2'b0, wave_o, irq_cmp_o, irq_cap_o, irq_ovf_o}, 8'h00);

    for (int i = 0; i < NV; i++) begin
      if (VEC[i][12]) wr(VEC[i][11:8], VEC[i][7:0]);
      else            rd(rtag(VEC[i][16:13]), VEC[i][11:8], VEC[i][7:0]);
    end

    // R10: free-running overflow
    wr16(4'h0, 16'hFFFE);
    ticks(2);
    rd("R10", 4'h9, 8'h01);
    rd("R10", 4'h0, 8'h00);
    rd("R10", 4'h1, 8'h00);
    // R12 / R13: mask gating and write-one-to-clear
    wr(4'h8, 8'h01);
    check("R12", {7'b0, irq_ovf_o}, 8'h01);
    wr(4'h9, 8'h00);
    rd("R13", 4'h9, 8'h01);
    wr(4'h9, 8'h01);
    check("R13", {7'b0, irq_ovf_o}, 8'h00);
    rd("R13", 4'h9, 8'h00);
    wr(4'h8, 8'h00);

    // R9: compare match after the blocked tick
    wr16(4'h2, 16'h0010);
    wr16(4'h0, 16'h000E);
    ticks(2);
    rd("R9", 4'h9, 8'h00);
    ticks(1);
    rd("R9", 4'h9, 8'h02);
    check("R9", {6'b0, wave_o}, 8'h01);
    wr(4'h9, 8'h02);

    // R3: write to counter blocks the match on both channels
    wr16(4'h4, 16'h0010);
    wr16(4'h0, 16'h0010);
    ticks(1);
    rd("R3", 4'h9, 8'h00);
    check("R3", {6'b0, wave_o}, 8'h01);
    wr16(4'h0, 16'h000F);
    ticks(2);
    rd("R3", 4'h9, 8'h06);
    check("R3", {6'b0, wave_o}, 8'h02);
    wr(4'h9, 8'h06);

    // R6: rising-edge capture
    wr(4'hA, 8'h04);
    wr16(4'h0, 16'h1234);
    set_pin(1'b1);
    rd("R6", 4'h9, 8'h20);
    rd("R6", 4'h6, 8'h34);
    rd("R6", 4'h7, 8'h12);
    // R4: high read returns byte latched by the low read
    wr16(4'h0, 16'h5678);
    rd("R4", 4'h6, 8'h34);
    set_pin(1'b0);
    set_pin(1'b1);
    rd("R4", 4'h7, 8'h12);
    rd("R4", 4'h6, 8'h78);
    rd("R4", 4'h7, 8'h56);
    // R5: shared holding byte
    wr(4'h3, 8'hAB);
    rd("R5", 4'h6, 8'h78);
    wr(4'h2, 8'hCD);
    rd("R5", 4'h3, 8'h56);
    rd("R5", 4'h2, 8'hCD);
    // R8: capture writes ignored, holding byte untouched
    wr(4'h1, 8'h3C);
    wr(4'h7, 8'h99);
    wr(4'h6, 8'h11);
    rd("R8", 4'h1, 8'h3C);
    rd("R8", 4'h6, 8'h78);
    // R6: falling-edge capture
    wr(4'hA, 8'h00);
    wr16(4'h0, 16'h0042);
    set_pin(1'b0);
    rd("R6", 4'h6, 8'h42);
    // R7: alternative source, pin ignored
    wr(4'h9, 8'hFF);
    wr(4'hA, 8'h02);
    wr16(4'h0, 16'h0099);
    set_pin(1'b1);
    set_pin(1'b0);
    rd("R7", 4'h6, 8'h42);
    rd("R7", 4'h9, 8'h00);
    set_alt(1'b1);
    set_alt(1'b0);
    rd("R7", 4'h6, 8'h99);
    // R12: capture interrupt gating
    wr(4'h8, 8'h20);
    check("R12", {6'b0, irq_cap_o, irq_ovf_o}, 8'h02);
    wr(4'h9, 8'h20);
    check("R12", {7'b0, irq_cap_o}, 8'h00);
    wr(4'h8, 8'h00);

    // R11: capture value as counter top
    wr(4'hA, 8'h01);
    wr16(4'h0, 16'h0097);
    ticks(3);
    rd("R11", 4'h0, 8'h00);
    rd("R11", 4'h1, 8'h00);
    ticks(1);
    rd("R11", 4'h0, 8'h01);
    rd("R11", 4'h9, 8'h00);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule